// File: doc/BRIEF.md
# Serial ADC Frame Reader

This block is the host side of a three-wire link to a 16-bit successive-approximation converter. When a conversion is requested, it lowers an active-low chip select. It then produces a serial clock divided down from the system clock and shifts in one frame from the converter's data line. The converter samples its analog input when chip select falls. It also runs its conversion from the serial clock, so every frame returns the sample taken at its own chip-select fall, with no pipeline delay.

A frame is either 20 or 24 serial clocks long. It holds four zero bits, then the 16-bit result MSB first, and in the long form four more zero bits. The reader removes the framing bits and presents the unsigned result with a one-cycle valid strobe. It flags a framing error when a framing bit is not zero. Between frames it holds chip select high for a programmable quiet time.

Requests come from a start pulse or from an internal periodic timer. A request that arrives while a frame or the quiet time is in progress is stored and served as soon as the quiet time ends.

The control is one state machine with six states:
- `ST_QUIET`: chip select is high while a quiet timer runs. This is also the reset state.
- `ST_IDLE`: waits for a stored request.
- `ST_SETUP`: chip select is low and the serial clock is still high.
- `ST_SCLK_LO`: low phase of the serial clock.
- `ST_SCLK_HI`: high phase of the serial clock.
- `ST_DONE`: chip select is back high and the valid strobe is raised.

The transitions are:
- QUIET→IDLE when the timer reaches `quiet_i`.
- IDLE→SETUP when a request is pending.
- SETUP→SCLK_LO after one half period.
- SCLK_LO→SCLK_HI after one half period. The data bit is sampled on this transition.
- SCLK_HI→SCLK_LO after one half period, while bits remain.
- SCLK_HI→DONE after one half period, once the last bit has been sampled.
- DONE→QUIET always, after one cycle.

Top module: `adc_frame_reader`

## Requirements
- R1: While reset is asserted, `cs_n_o` and `sclk_o` are 1, `result_valid_o` and `frame_err_o` are 0, and `result_o` is 0x0000.
- R2: `sclk_o` is high whenever `cs_n_o` is high. After `cs_n_o` falls, `sclk_o` stays high for at least one half period before its first falling edge.
- R3: While `cs_n_o` is low, each half period of `sclk_o` lasts `half_div_i` system clocks, so the period is 2·`half_div_i` clocks. A value of 0 is treated as 1.
- R4: A frame has exactly 20 rising edges of `sclk_o` when `long_frame_i`=0, and 24 when it is 1.
- R5: `sdata_i` is sampled at each rising edge of `sclk_o`. Frame bits 0–3 are leading framing bits and bits 4–19 are the result, MSB first. The result is plain unsigned binary, from 0x0000 to 0xFFFF.
- R6: `result_valid_o` is high for exactly one system clock: the first cycle in which `cs_n_o` is high again. `result_o` changes only in that cycle and holds its value until the next frame completes.
- R7: `frame_err_o` (updated together with `result_o`) is 1 when any of frame bits 0–3 is 1, or, in 24-clock frames, when any of bits 20–23 is 1. Otherwise it is 0.
- R8: `cs_n_o` stays high for at least `quiet_i`+2 system clocks before it falls again. This applies after a frame and also after reset.
- R9: A request received during a frame or during the quiet time is stored. Its frame starts no later than `quiet_i`+3 clocks after `cs_n_o` rose. Several requests received before the frame starts produce only one frame.
- R10: With `cont_en_i`=1, a request is made every `rate_i` system clocks. When `rate_i` exceeds the frame length plus quiet time, `cs_n_o` falls exactly every `rate_i` clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | One-cycle request for a conversion |
| cont_en_i | input | 1 | Enables periodic requests |
| rate_i | input | 16 | Interval between periodic requests, in clocks |
| half_div_i | input | 8 | Serial clock half period, in clocks |
| long_frame_i | input | 1 | 0: 20-clock frame, 1: 24-clock frame |
| quiet_i | input | 12 | Minimum quiet time, in clocks |
| sdata_i | input | 1 | Serial data from the converter |
| cs_n_o | output | 1 | Active-low chip select |
| sclk_o | output | 1 | Serial clock to the converter |
| result_o | output | 16 | Last conversion result |
| result_valid_o | output | 1 | One-cycle strobe for a new result |
| frame_err_o | output | 1 | Framing-bit error of the last frame |

## Verification
The frame-length and quiet-gap properties compare against the live `long_frame_i` and `quiet_i` ports. They therefore assume that these settings change only while no frame is open and no quiet time is running. The bench changes them only after a result has been delivered and the quiet time has expired. The converter model changes `sdata_i` only on falling edges of `sclk_o`, so the data line is always stable for a half period before the sampling edge. Periodic mode is exercised only with an interval longer than one frame plus the quiet time, which is the condition the exact-spacing property needs.

// File: rtl/adc_fr_pkg.sv
package adc_fr_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SETUP,
        ST_SCLK_LO,
        ST_SCLK_HI,
        ST_DONE,
        ST_QUIET
    } fr_state_t;

endpackage

// File: rtl/adc_fr_halfclk.sv
// Half-period timer for the serial clock: tick marks the last system
// clock of each half period while run is high.
module adc_fr_halfclk #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [DIV_W-1:0] half_div,
    output logic             tick
);

    logic [DIV_W-1:0] cnt;
    logic [DIV_W-1:0] limit;

    // a zero divider is treated as one
    assign limit = (half_div == '0) ? '0 : half_div - 1'b1;
    assign tick  = run && (cnt == limit);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (!run || tick) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

endmodule

// File: rtl/adc_fr_rate.sv
// Periodic request generator for continuous conversion.
module adc_fr_rate #(
    parameter int RATE_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable,
    input  logic [RATE_W-1:0] period,
    output logic              tick
);

    logic [RATE_W-1:0] cnt;
    logic [RATE_W-1:0] limit;

    assign limit = (period == '0) ? '0 : period - 1'b1;
    assign tick  = enable && (cnt >= limit);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (!enable || tick) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

endmodule

// File: rtl/adc_fr_shift.sv
// Frame shift register with field extraction for both frame lengths.
module adc_fr_shift #(
    parameter int DATA_W  = 16,
    parameter int LEAD_W  = 4,
    parameter int TRAIL_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              sample_en,
    input  logic              sdata,
    input  logic              long_mode,
    output logic [DATA_W-1:0] data_o,
    output logic              err_o
);

    localparam int SHORT_LEN = LEAD_W + DATA_W;
    localparam int LONG_LEN  = SHORT_LEN + TRAIL_W;

    logic [LONG_LEN-1:0] sh;
    logic [LEAD_W-1:0]   lead_s, lead_l;
    logic [DATA_W-1:0]   data_s, data_l;
    logic [TRAIL_W-1:0]  trail_l;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sh <= '0;
        end else if (clear) begin
            sh <= '0;
        end else if (sample_en) begin
            sh <= {sh[LONG_LEN-2:0], sdata};
        end
    end

    // short frame: the newest SHORT_LEN bits; long frame: all bits
    assign lead_s  = sh[SHORT_LEN-1 -: LEAD_W];
    assign data_s  = sh[DATA_W-1:0];
    assign lead_l  = sh[LONG_LEN-1 -: LEAD_W];
    assign data_l  = sh[TRAIL_W +: DATA_W];
    assign trail_l = sh[TRAIL_W-1:0];

    always_comb begin
        if (long_mode) begin
            data_o = data_l;
            err_o  = (|lead_l) || (|trail_l);
        end else begin
            data_o = data_s;
            err_o  = |lead_s;
        end
    end

endmodule

// File: rtl/adc_frame_reader.sv
module adc_frame_reader #(
    parameter int DATA_W  = 16,
    parameter int LEAD_W  = 4,
    parameter int TRAIL_W = 4,
    parameter int DIV_W   = 8,
    parameter int QUIET_W = 12,
    parameter int RATE_W  = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start_i,
    input  logic               cont_en_i,
    input  logic [RATE_W-1:0]  rate_i,
    input  logic [DIV_W-1:0]   half_div_i,
    input  logic               long_frame_i,
    input  logic [QUIET_W-1:0] quiet_i,
    input  logic               sdata_i,
    output logic               cs_n_o,
    output logic               sclk_o,
    output logic [DATA_W-1:0]  result_o,
    output logic               result_valid_o,
    output logic               frame_err_o
);

    import adc_fr_pkg::*;

    localparam int SHORT_LEN = LEAD_W + DATA_W;
    localparam int LONG_LEN  = SHORT_LEN + TRAIL_W;
    localparam int BCNT_W    = $clog2(LONG_LEN + 1);
    localparam logic [BCNT_W-1:0] SHORT_CNT = BCNT_W'(SHORT_LEN);
    localparam logic [BCNT_W-1:0] LONG_CNT  = BCNT_W'(LONG_LEN);

    fr_state_t          state, nxt;
    logic [DIV_W-1:0]   half_q;
    logic               long_q;
    logic [BCNT_W-1:0]  bcnt;
    logic [QUIET_W-1:0] qcnt;
    logic               pend;
    logic [DATA_W-1:0]  result_q;
    logic               err_q;

    logic               run, tick, rate_tick, take, sample_en, last_bit;
    logic               quiet_done, capture;
    logic [DATA_W-1:0]  sh_data;
    logic               sh_err;

    assign run        = (state == ST_SETUP) || (state == ST_SCLK_LO) || (state == ST_SCLK_HI);
    assign take       = (state == ST_IDLE) && pend;
    assign sample_en  = (state == ST_SCLK_LO) && tick;
    assign last_bit   = (bcnt == (long_q ? LONG_CNT : SHORT_CNT));
    assign capture    = (state == ST_SCLK_HI) && tick && last_bit;
    assign quiet_done = (qcnt >= quiet_i);

    adc_fr_halfclk #(.DIV_W(DIV_W)) u_halfclk (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (run),
        .half_div (half_q),
        .tick     (tick)
    );

    adc_fr_rate #(.RATE_W(RATE_W)) u_rate (
        .clk    (clk),
        .rst_n  (rst_n),
        .enable (cont_en_i),
        .period (rate_i),
        .tick   (rate_tick)
    );

    adc_fr_shift #(.DATA_W(DATA_W), .LEAD_W(LEAD_W), .TRAIL_W(TRAIL_W)) u_shift (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear     (take),
        .sample_en (sample_en),
        .sdata     (sdata_i),
        .long_mode (long_q),
        .data_o    (sh_data),
        .err_o     (sh_err)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_QUIET;
        end else begin
            state <= nxt;
        end
    end

    // next state
    always_comb begin
        nxt = state;
        unique case (state)
            ST_QUIET:   if (quiet_done) nxt = ST_IDLE;
            ST_IDLE:    if (pend)       nxt = ST_SETUP;
            ST_SETUP:   if (tick)       nxt = ST_SCLK_LO;
            ST_SCLK_LO: if (tick)       nxt = ST_SCLK_HI;
            ST_SCLK_HI: if (tick)       nxt = last_bit ? ST_DONE : ST_SCLK_LO;
            ST_DONE:                    nxt = ST_QUIET;
            default:                    nxt = ST_IDLE;
        endcase
    end

    // counters, request memory and result registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            half_q   <= '0;
            long_q   <= 1'b0;
            bcnt     <= '0;
            qcnt     <= '0;
            pend     <= 1'b0;
            result_q <= '0;
            err_q    <= 1'b0;
        end else begin
            pend <= (pend && !take) || start_i || rate_tick;
            if (take) begin
                half_q <= half_div_i;
                long_q <= long_frame_i;
                bcnt   <= '0;
            end else if (sample_en) begin
                bcnt <= bcnt + 1'b1;
            end
            if (capture) begin
                result_q <= sh_data;
                err_q    <= sh_err;
            end
            if (state == ST_DONE) begin
                qcnt <= '0;
            end else if ((state == ST_QUIET) && !quiet_done) begin
                qcnt <= qcnt + 1'b1;
            end
        end
    end

    // outputs
    always_comb begin
        cs_n_o         = !run;
        sclk_o         = (state != ST_SCLK_LO);
        result_valid_o = (state == ST_DONE);
        result_o       = result_q;
        frame_err_o    = err_q;
    end

endmodule

// File: rtl/adc_fr_checker.sv
module adc_fr_checker #(
    parameter int DATA_W  = 16,
    parameter int LEAD_W  = 4,
    parameter int TRAIL_W = 4,
    parameter int QUIET_W = 12
) (
    input logic               clk,
    input logic               rst_n,
    input logic               long_frame_i,
    input logic [QUIET_W-1:0] quiet_i,
    input logic               cs_n_o,
    input logic               sclk_o,
    input logic [DATA_W-1:0]  result_o,
    input logic               result_valid_o
);

    localparam int SHORT_LEN = LEAD_W + DATA_W;
    localparam int LONG_LEN  = SHORT_LEN + TRAIL_W;
    localparam int HI_W      = QUIET_W + 2;

    logic [HI_W-1:0] hi_cnt;
    logic [7:0]      rise_cnt;
    logic            sclk_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hi_cnt   <= '0;
            rise_cnt <= '0;
            sclk_d   <= 1'b1;
        end else begin
            sclk_d <= sclk_o;
            if (!cs_n_o) begin
                hi_cnt <= '0;
            end else if (hi_cnt != '1) begin
                hi_cnt <= hi_cnt + 1'b1;
            end
            if (cs_n_o) begin
                rise_cnt <= '0;
            end else if (sclk_o && !sclk_d) begin
                rise_cnt <= rise_cnt + 1'b1;
            end
        end
    end

    AST_IDLE_SCLK_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n_o |-> sclk_o); // R2

    AST_FRAME_CLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cs_n_o) |-> (rise_cnt == (long_frame_i ? 8'(LONG_LEN) : 8'(SHORT_LEN)))); // R4

    AST_VALID_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        result_valid_o |=> !result_valid_o); // R6

    AST_VALID_AT_CS_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        result_valid_o |-> $rose(cs_n_o)); // R6

    AST_RESULT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        !result_valid_o |-> $stable(result_o)); // R6

    AST_QUIET_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cs_n_o) |-> (hi_cnt >= ({2'b00, quiet_i} + HI_W'(2)))); // R8

endmodule

bind adc_frame_reader adc_fr_checker #(
    .DATA_W  (DATA_W),
    .LEAD_W  (LEAD_W),
    .TRAIL_W (TRAIL_W),
    .QUIET_W (QUIET_W)
) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .long_frame_i   (long_frame_i),
    .quiet_i        (quiet_i),
    .cs_n_o         (cs_n_o),
    .sclk_o         (sclk_o),
    .result_o       (result_o),
    .result_valid_o (result_valid_o)
);

// File: tb/test_adc_frame_reader.sv
`timescale 1ns/1ps
module test_adc_frame_reader;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic        cont_en_i = 1'b0;
    logic [15:0] rate_i = 16'd100;
    logic [7:0]  half_div_i = 8'd2;
    logic        long_frame_i = 1'b0;
    logic [11:0] quiet_i = 12'd4;
    logic        sdata_i = 1'b0;
    logic        cs_n_o, sclk_o, result_valid_o, frame_err_o;
    logic [15:0] result_o;

    int checks = 0;
    int failures = 0;
    int cyc = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;   // 125 MHz

    adc_frame_reader i_adc_frame_reader (
        .clk            (clk),
        .rst_n          (rst_n),
        .start_i        (start_i),
        .cont_en_i      (cont_en_i),
        .rate_i         (rate_i),
        .half_div_i     (half_div_i),
        .long_frame_i   (long_frame_i),
        .quiet_i        (quiet_i),
        .sdata_i        (sdata_i),
        .cs_n_o         (cs_n_o),
        .sclk_o         (sclk_o),
        .result_o       (result_o),
        .result_valid_o (result_valid_o),
        .frame_err_o    (frame_err_o)
    );

    // converter model: next frame bit on every falling serial clock
    logic [3:0]  m_lead = 4'h0;
    logic [15:0] m_data = 16'h0;
    logic [3:0]  m_trail = 4'h0;
    logic [23:0] frv = '0;
    int          idx = 0;

    always @(negedge cs_n_o) begin
        frv = {m_lead, m_data, m_trail};
        idx = 0;
    end

    always @(negedge sclk_o) begin
        if (!cs_n_o && idx < 24) begin
            sdata_i = frv[23 - idx];
            idx = idx + 1;
        end
    end

    // monitor
    int frames = 0, fall_cyc = 0, prev_fall = 0, rise_cyc = 0, gap = 0;
    int rises = 0, first_sfall = -1, last_sfall = 0, s_period = 0;
    int vrun = 0, vmax = 0;
    bit bad_idle = 1'b0, bad_vcs = 1'b0;
    logic cs_d = 1'b1, sclk_d = 1'b1;

    always @(posedge clk) cyc <= cyc + 1;

    always @(negedge clk) begin
        if (rst_n) begin
            if (cs_d && !cs_n_o) begin
                frames = frames + 1;
                prev_fall = fall_cyc;
                fall_cyc = cyc;
                gap = cyc - rise_cyc;
                rises = 0;
                first_sfall = -1;
            end
            if (!cs_d && cs_n_o) rise_cyc = cyc;
            if (!cs_n_o && sclk_d && !sclk_o) begin
                if (first_sfall < 0) first_sfall = cyc;
                else s_period = cyc - last_sfall;
                last_sfall = cyc;
            end
            if (!cs_n_o && !sclk_d && sclk_o) rises = rises + 1;
            if (cs_n_o && !sclk_o) bad_idle = 1'b1;
            if (result_valid_o) begin
                vrun = vrun + 1;
                if (!cs_n_o) bad_vcs = 1'b1;
            end else begin
                vrun = 0;
            end
            if (vrun > vmax) vmax = vrun;
            cs_d = cs_n_o;
            sclk_d = sclk_o;
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic tick(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            #1;
        end
    endtask

    task automatic pulse_start();
        @(negedge clk);
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
    endtask

    task automatic wait_valid(output bit ok);
        ok = 1'b0;
        for (int i = 0; i < 3000; i++) begin
            @(negedge clk);
            #1;
            if (result_valid_o) begin
                ok = 1'b1;
                break;
            end
        end
    endtask

    task automatic run_frame(input logic [3:0] ld, input logic [15:0] d,
                             input logic [3:0] tr, input bit lng, input int half,
                             output logic [15:0] r, output logic e);
        bit ok;
        m_lead = ld; m_data = d; m_trail = tr;
        long_frame_i = lng;
        half_div_i = 8'(half);
        pulse_start();
        wait_valid(ok);
        chk(ok, "R6", "valid seen", int'(ok), 1);
        r = result_o;
        e = frame_err_o;
        tick(1);
    endtask

    task automatic t_reset();
        chk(cs_n_o == 1'b1, "R1", "cs_n in reset", cs_n_o, 1);
        chk(sclk_o == 1'b1, "R1", "sclk in reset", sclk_o, 1);
        chk(result_valid_o == 1'b0, "R1", "valid in reset", result_valid_o, 0);
        chk(frame_err_o == 1'b0, "R1", "err in reset", frame_err_o, 0);
        chk(result_o == 16'h0, "R1", "result in reset", result_o, 0);
    endtask

    task automatic t_basic();
        logic [15:0] r; logic e;
        run_frame(4'h0, 16'hA5C3, 4'h0, 1'b0, 2, r, e);
        chk(r == 16'hA5C3, "R5", "short frame result", r, 16'hA5C3);
        chk(e == 1'b0, "R7", "clean frame err", e, 0);
        chk(rises == 20, "R4", "short frame rising edges", rises, 20);
        chk(first_sfall - fall_cyc >= 2, "R2", "cs to first sclk fall", first_sfall - fall_cyc, 2);
        chk(s_period == 4, "R3", "sclk period half=2", s_period, 4);
        chk(vmax == 1, "R6", "valid pulse width", vmax, 1);
        chk(result_valid_o == 1'b0, "R6", "valid low after pulse", result_valid_o, 0);
        chk(!bad_vcs, "R6", "valid only with cs high", bad_vcs, 0);
    endtask

    task automatic t_long();
        logic [15:0] r; logic e;
        run_frame(4'h0, 16'h0001, 4'h0, 1'b1, 3, r, e);
        chk(r == 16'h0001, "R5", "long frame result", r, 1);
        chk(rises == 24, "R4", "long frame rising edges", rises, 24);
        chk(s_period == 6, "R3", "sclk period half=3", s_period, 6);
        chk(e == 1'b0, "R7", "long clean err", e, 0);
        run_frame(4'h0, 16'hFFFF, 4'h0, 1'b1, 1, r, e);
        chk(r == 16'hFFFF, "R5", "full scale", r, 16'hFFFF);
        run_frame(4'h0, 16'h0000, 4'h0, 1'b0, 0, r, e);
        chk(r == 16'h0000, "R5", "zero scale", r, 0);
        chk(s_period == 2, "R3", "zero divider as one", s_period, 2);
    endtask

    task automatic t_errors();
        logic [15:0] r; logic e;
        run_frame(4'b0100, 16'h1234, 4'h0, 1'b0, 1, r, e);
        chk(e == 1'b1, "R7", "leading bit set", e, 1);
        chk(r == 16'h1234, "R5", "data beside bad lead", r, 16'h1234);
        run_frame(4'h0, 16'h4321, 4'b0001, 1'b1, 1, r, e);
        chk(e == 1'b1, "R7", "trailing bit set long", e, 1);
        run_frame(4'h0, 16'h4321, 4'b0001, 1'b0, 1, r, e);
        chk(e == 1'b0, "R7", "trailing bits unclocked short", e, 0);
        chk(rises == 20, "R4", "short frame edges again", rises, 20);
    endtask

    task automatic t_hold();
        logic [15:0] r0;
        r0 = result_o;
        m_data = 16'hDEAD;
        tick(200);
        chk(result_o == r0, "R6", "result held while idle", result_o, r0);
        chk(result_valid_o == 1'b0, "R6", "no valid while idle", result_valid_o, 0);
        chk(!bad_idle, "R2", "sclk high while cs high", bad_idle, 0);
    endtask

    task automatic t_queue();
        bit ok; int f;
        quiet_i = 12'd40;
        half_div_i = 8'd2;
        long_frame_i = 1'b0;
        m_lead = 4'h0; m_trail = 4'h0; m_data = 16'h0F0F;
        pulse_start();
        tick(10);
        pulse_start();
        tick(3);
        pulse_start();
        wait_valid(ok);
        chk(ok, "R9", "first queued frame done", int'(ok), 1);
        m_data = 16'h3C3C;
        wait_valid(ok);
        chk(ok, "R9", "stored request served", int'(ok), 1);
        chk(result_o == 16'h3C3C, "R5", "second frame data", result_o, 16'h3C3C);
        chk(gap >= 42, "R8", "quiet gap lower bound", gap, 42);
        chk(gap <= 43, "R9", "stored request promptness", gap, 43);
        f = frames;
        tick(200);
        chk(frames == f, "R9", "requests merged into one frame", frames, f);
        pulse_start();
        wait_valid(ok);
        tick(5);
        pulse_start();
        wait_valid(ok);
        chk(ok, "R9", "request during quiet served", int'(ok), 1);
        chk(gap >= 42 && gap <= 43, "R9", "gap after quiet request", gap, 43);
        tick(100);
    endtask

    task automatic t_cont();
        int f;
        quiet_i = 12'd4;
        half_div_i = 8'd1;
        long_frame_i = 1'b0;
        rate_i = 16'd100;
        cont_en_i = 1'b1;
        f = frames;
        for (int i = 0; i < 2000 && frames < f + 3; i++) tick(1);
        chk(frames >= f + 3, "R10", "periodic frames seen", frames - f, 3);
        chk(fall_cyc - prev_fall == 100, "R10", "periodic spacing", fall_cyc - prev_fall, 100);
        f = frames;
        for (int i = 0; i < 2000 && frames < f + 1; i++) tick(1);
        chk(fall_cyc - prev_fall == 100, "R10", "periodic spacing again", fall_cyc - prev_fall, 100);
        cont_en_i = 1'b0;
        tick(200);
    endtask

    initial begin
        tick(5);
        t_reset();
        @(negedge clk);
        rst_n = 1'b1;
        tick(20);
        t_basic();
        t_long();
        t_errors();
        t_hold();
        t_queue();
        t_cont();
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        #1200000;
        if (!done) begin
            done = 1'b1;
            checks++;
            failures++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule